// File: doc/BRIEF.md
# Voltage-Level and Clock-Divider Decision Controller

This controller turns a stream of periodic memory-time samples into two frequency settings for a processor core. One setting is a slow voltage/frequency level that a regulator can only follow occasionally. The other is a fast digital clock-divider level that can be changed on every sample. Each sample gives the time the core spent waiting on memory, together with the length of the interval it covers. Both values are in absolute time units (nanoseconds by default), not processor cycles, because the frequency may change while the window is filling.

The voltage level is chosen from one of two sources. In averaging mode it comes from a sliding-window average of the samples, and a change is allowed only when the resulting level has held steady for a programmable time and the minimum spacing since the last change has passed. In dense mode each sample is compared directly and acts as soon as the spacing allows. Whenever the voltage level moves, the divider returns to no division. Otherwise the divider level follows the current sample alone.

Level code k on either output means (k+1)/8 of the frequency above it: code 7 is full speed and code 0 is one eighth. Samples must arrive at least DEPTH+3 cycles apart and must have a non-zero length.

Top module: `dvfs_freq_governor`

## Requirements
- R1: After reset, `dvfsLevel` is 7, `divLevel` is 7, both change strobes are low, and the spacing timer counts as already expired.
- R2: In averaging mode, the fraction used is the sum of the stored memory times divided by the sum of their lengths. A stored sample leaves the window once the accumulated time minus its end time reaches WINDOW_TIME (25000 units by default).
- R3: Window age, spacing and steadiness are measured by adding up the `sampleLen` values. The number of clock cycles between samples has no effect.
- R4: Two voltage-level changes are separated by more than HOLDOFF_TIME (100000 units) of accumulated sample time. A change exactly at HOLDOFF_TIME is held back.
- R5: `cfgStableSel` sets the steadiness limit: 1, 2, 3 and 4 select 1x, 2x, 4x and 8x STABLE_BASE (1250 units). Codes 0 and 5 to 7 mean no limit. In averaging mode, a change needs the averaged target level to have stayed the same over at least that much time. The time counts from the sample after the target last moved.
- R6: A voltage-level change updates `dvfsLevel`, pulses `dvfsChange` for one cycle and sets `divLevel` to 7. `divChange` pulses only if `divLevel` was not already 7. Neither level moves without its strobe.
- R7: On a sample that causes no voltage-level change, `divLevel` becomes the smallest code t<7 for which the sample's fraction is strictly above threshold row 7, column t, or 7 if there is none. `divChange` pulses when the value changes.
- R8: With `cfgDense` high, the voltage target uses the current sample's fraction, and the steadiness limit is ignored.
- R9: The downward target is the smallest code t below the current level whose threshold (row = current level, column t) is strictly below the fraction.
- R10: If no downward target exists, the upward target is the largest code t above the current level whose threshold is strictly above the fraction.
- R11: The threshold for row c and column t sits at `cfgThr[8*(8*c+t) +: 8]`, read as a fraction in 1/256 steps. Comparisons use cross-multiplication: mem*256 against threshold*length.
- R12: When all DEPTH (16) entries are in use, a new sample pushes out the oldest entry, even if that entry is still inside the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | One-cycle strobe that delivers a sample |
| sampleMem | input | SAMP_W | Memory time within the sample interval |
| sampleLen | input | SAMP_W | Length of the sample interval |
| cfgDense | input | 1 | 1 = per-sample voltage decision, 0 = averaged |
| cfgStableSel | input | 3 | Steadiness limit select |
| cfgThr | input | 512 | 8x8 table of 8-bit thresholds |
| dvfsLevel | output | 3 | Voltage/frequency level code |
| divLevel | output | 3 | Clock-divider level code |
| dvfsChange | output | 1 | Pulse when dvfsLevel changes |
| divChange | output | 1 | Pulse when divLevel changes |

## Verification
The voltage decision and the divider decision are made in the same cycle on the same sample. The sample that finally releases a voltage change is also one that, taken alone, asks for heavy division. The bench provokes this in two ways: by letting the steadiness limit run out on a third identical sample, and by letting the spacing timer run out while every sample is fully memory-bound. It judges the result by requiring `divLevel` to read 7 together with the new `dvfsLevel`, even though the last sample by itself would have given a divider code of 0 or 4. The strobe counts then show one divider pulse for the reset. The reverse case, where the divider was already at 7, must show no divider pulse.

// File: rtl/dvfs_dec_pkg.sv
`timescale 1ns/1ps
package dvfs_dec_pkg;
  localparam int LVL_W    = 3;
  localparam int NUM_LVL  = 8;
  localparam int THR_W    = 8;
  localparam int THR_BITS = NUM_LVL * NUM_LVL * THR_W;
  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(NUM_LVL - 1);

  typedef struct packed {
    logic push;
    logic pop;
  } dpCtrl_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_EVICT  = 2'd1,
    ST_DECIDE = 2'd2
  } decState_t;
endpackage

// File: rtl/dvfs_dec_datapath.sv
`timescale 1ns/1ps
module dvfs_dec_datapath
  import dvfs_dec_pkg::*;
#(
  parameter int TIME_W      = 32,
  parameter int SAMP_W      = 16,
  parameter int DEPTH       = 16,
  parameter int WINDOW_TIME = 25000
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCtrl_t             ctrl,
  input  logic [SAMP_W-1:0]   sampleMem,
  input  logic [SAMP_W-1:0]   sampleLen,
  input  logic                cfgDense,
  input  logic [THR_BITS-1:0] cfgThr,
  input  logic [LVL_W-1:0]    curLevel,
  output logic                oldStale,
  output logic [LVL_W-1:0]    dvfsTarget,
  output logic [LVL_W-1:0]    divTarget,
  output logic [SAMP_W-1:0]   lastLen
);
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int SUM_W  = SAMP_W + CNT_W;
  localparam int PROD_W = SUM_W + THR_W;

  // circular window storage
  logic [SAMP_W-1:0] memBuf [DEPTH];
  logic [SAMP_W-1:0] lenBuf [DEPTH];
  logic [TIME_W-1:0] tsBuf  [DEPTH];

  logic [PTR_W-1:0]  head;
  logic [CNT_W-1:0]  count;
  logic [SUM_W-1:0]  memSum, lenSum;
  logic [TIME_W-1:0] nowT;
  logic [SAMP_W-1:0] latMem, latLen;

  logic              full;
  logic [PTR_W-1:0]  tail;
  logic [TIME_W-1:0] oldAge;
  logic [TIME_W-1:0] pushTs;

  assign full   = (count == CNT_W'(DEPTH));
  assign tail   = head + count[PTR_W-1:0];
  assign pushTs = nowT + TIME_W'(sampleLen);
  assign oldAge = nowT - tsBuf[head];
  assign oldStale = (count != '0) && (oldAge >= TIME_W'(WINDOW_TIME));
  assign lastLen  = latLen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      head   <= '0;
      count  <= '0;
      memSum <= '0;
      lenSum <= '0;
      nowT   <= '0;
      latMem <= '0;
      latLen <= '0;
    end else if (ctrl.push) begin
      nowT   <= pushTs;
      latMem <= sampleMem;
      latLen <= sampleLen;
      if (full) begin
        head   <= head + PTR_W'(1);
        memSum <= memSum + SUM_W'(sampleMem) - SUM_W'(memBuf[head]);
        lenSum <= lenSum + SUM_W'(sampleLen) - SUM_W'(lenBuf[head]);
      end else begin
        count  <= count + CNT_W'(1);
        memSum <= memSum + SUM_W'(sampleMem);
        lenSum <= lenSum + SUM_W'(sampleLen);
      end
    end else if (ctrl.pop) begin
      head   <= head + PTR_W'(1);
      count  <= count - CNT_W'(1);
      memSum <= memSum - SUM_W'(memBuf[head]);
      lenSum <= lenSum - SUM_W'(lenBuf[head]);
    end
  end

  always_ff @(posedge clk) begin
    if (ctrl.push) begin
      memBuf[tail] <= sampleMem;
      lenBuf[tail] <= sampleLen;
      tsBuf[tail]  <= pushTs;
    end
  end

  // fraction source for the voltage decision
  logic [SUM_W-1:0]  srcMem, srcLen;
  logic [PROD_W-1:0] lhsDvfs, lhsDiv;
  assign srcMem  = cfgDense ? SUM_W'(latMem) : memSum;
  assign srcLen  = cfgDense ? SUM_W'(latLen) : lenSum;
  assign lhsDvfs = {srcMem, {THR_W{1'b0}}};
  assign lhsDiv  = {SUM_W'(latMem), {THR_W{1'b0}}};

  logic [NUM_LVL-1:0] gtDvfs, ltDvfs, gtDiv;

  for (genvar t = 0; t < NUM_LVL; t++) begin : g_cmp
    logic [THR_W-1:0]  thrDvfs, thrDiv;
    logic [PROD_W-1:0] rhsDvfs, rhsDiv;
    assign thrDvfs = cfgThr[THR_W*(NUM_LVL*int'(curLevel) + t) +: THR_W];
    assign thrDiv  = cfgThr[THR_W*(NUM_LVL*(NUM_LVL-1) + t) +: THR_W];
    assign rhsDvfs = PROD_W'(thrDvfs) * PROD_W'(srcLen);
    assign rhsDiv  = PROD_W'(thrDiv) * PROD_W'(latLen);
    assign gtDvfs[t] = lhsDvfs > rhsDvfs;
    assign ltDvfs[t] = lhsDvfs < rhsDvfs;
    assign gtDiv[t]  = lhsDiv > rhsDiv;
  end

  logic downHit;
  always_comb begin
    dvfsTarget = curLevel;
    downHit    = 1'b0;
    for (int t = NUM_LVL - 1; t >= 0; t--) begin
      if (LVL_W'(t) < curLevel && gtDvfs[t]) begin
        dvfsTarget = LVL_W'(t);
        downHit    = 1'b1;
      end
    end
    if (!downHit) begin
      for (int t = 0; t < NUM_LVL; t++) begin
        if (LVL_W'(t) > curLevel && ltDvfs[t]) dvfsTarget = LVL_W'(t);
      end
    end
  end

  always_comb begin
    divTarget = TOP_LVL;
    for (int t = NUM_LVL - 2; t >= 0; t--) begin
      if (gtDiv[t]) divTarget = LVL_W'(t);
    end
  end
endmodule

// File: rtl/dvfs_dec_control.sv
`timescale 1ns/1ps
module dvfs_dec_control
  import dvfs_dec_pkg::*;
#(
  parameter int SAMP_W       = 16,
  parameter int HOLDOFF_TIME = 100000,
  parameter int STABLE_BASE  = 1250
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic              oldStale,
  input  logic [LVL_W-1:0]  dvfsTarget,
  input  logic [LVL_W-1:0]  divTarget,
  input  logic [SAMP_W-1:0] lastLen,
  input  logic              cfgDense,
  input  logic [2:0]        cfgStableSel,
  output dpCtrl_t           ctrl,
  output logic [LVL_W-1:0]  dvfsLevel,
  output logic [LVL_W-1:0]  divLevel,
  output logic              dvfsChange,
  output logic              divChange
);
  localparam int HOLD_CAP = HOLDOFF_TIME + 1;
  localparam int HACC_W   = $clog2(HOLD_CAP + 2**SAMP_W + 1);
  localparam int STAB_MAX = STABLE_BASE * 8;
  localparam int SACC_W   = $clog2(STAB_MAX + 2**SAMP_W + 1);

  decState_t         state;
  logic [HACC_W-1:0] holdAcc, holdSum, holdNext;
  logic [SACC_W-1:0] stabAcc, stabSum, stabNext, stabLimit;
  logic [LVL_W-1:0]  trackLvl;
  logic              holdOk, stableOk, doDvfs;

  always_comb begin
    ctrl      = '0;
    ctrl.push = (state == ST_IDLE) && sampleValid;
    ctrl.pop  = (state == ST_EVICT) && oldStale;
  end

  always_comb begin
    case (cfgStableSel)
      3'd1:    stabLimit = SACC_W'(STABLE_BASE);
      3'd2:    stabLimit = SACC_W'(STABLE_BASE * 2);
      3'd3:    stabLimit = SACC_W'(STABLE_BASE * 4);
      3'd4:    stabLimit = SACC_W'(STABLE_BASE * 8);
      default: stabLimit = '0;
    endcase
  end

  assign holdSum  = holdAcc + HACC_W'(lastLen);
  assign holdNext = (holdSum > HACC_W'(HOLD_CAP)) ? HACC_W'(HOLD_CAP) : holdSum;
  assign stabSum  = stabAcc + SACC_W'(lastLen);
  assign stabNext = (dvfsTarget != trackLvl) ? '0 :
                    (stabSum > SACC_W'(STAB_MAX)) ? SACC_W'(STAB_MAX) : stabSum;
  assign holdOk   = holdNext > HACC_W'(HOLDOFF_TIME);
  assign stableOk = cfgDense || (stabLimit == '0) || (stabNext >= stabLimit);
  assign doDvfs   = holdOk && stableOk && (dvfsTarget != dvfsLevel);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      holdAcc    <= HACC_W'(HOLD_CAP);
      stabAcc    <= '0;
      trackLvl   <= TOP_LVL;
      dvfsLevel  <= TOP_LVL;
      divLevel   <= TOP_LVL;
      dvfsChange <= 1'b0;
      divChange  <= 1'b0;
    end else begin
      dvfsChange <= 1'b0;
      divChange  <= 1'b0;
      case (state)
        ST_IDLE: if (sampleValid) state <= ST_EVICT;
        ST_EVICT: if (!oldStale) state <= ST_DECIDE;
        ST_DECIDE: begin
          state    <= ST_IDLE;
          trackLvl <= dvfsTarget;
          stabAcc  <= stabNext;
          if (doDvfs) begin
            dvfsLevel  <= dvfsTarget;
            dvfsChange <= 1'b1;
            holdAcc    <= '0;
            divLevel   <= TOP_LVL;
            divChange  <= (divLevel != TOP_LVL);
          end else begin
            holdAcc   <= holdNext;
            divLevel  <= divTarget;
            divChange <= (divTarget != divLevel);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dvfs_freq_governor.sv
`timescale 1ns/1ps
module dvfs_freq_governor
  import dvfs_dec_pkg::*;
#(
  parameter int TIME_W       = 32,
  parameter int SAMP_W       = 16,
  parameter int DEPTH        = 16,
  parameter int WINDOW_TIME  = 25000,
  parameter int HOLDOFF_TIME = 100000,
  parameter int STABLE_BASE  = 1250
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMP_W-1:0]   sampleMem,
  input  logic [SAMP_W-1:0]   sampleLen,
  input  logic                cfgDense,
  input  logic [2:0]          cfgStableSel,
  input  logic [THR_BITS-1:0] cfgThr,
  output logic [LVL_W-1:0]    dvfsLevel,
  output logic [LVL_W-1:0]    divLevel,
  output logic                dvfsChange,
  output logic                divChange
);
  dpCtrl_t           ctrl;
  logic              oldStale;
  logic [LVL_W-1:0]  dvfsTarget, divTarget;
  logic [SAMP_W-1:0] lastLen;

  dvfs_dec_datapath #(
    .TIME_W(TIME_W), .SAMP_W(SAMP_W), .DEPTH(DEPTH), .WINDOW_TIME(WINDOW_TIME)
  ) dataPath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .sampleMem(sampleMem), .sampleLen(sampleLen),
    .cfgDense(cfgDense), .cfgThr(cfgThr), .curLevel(dvfsLevel),
    .oldStale(oldStale), .dvfsTarget(dvfsTarget), .divTarget(divTarget),
    .lastLen(lastLen)
  );

  dvfs_dec_control #(
    .SAMP_W(SAMP_W), .HOLDOFF_TIME(HOLDOFF_TIME), .STABLE_BASE(STABLE_BASE)
  ) control (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .oldStale(oldStale), .dvfsTarget(dvfsTarget), .divTarget(divTarget),
    .lastLen(lastLen), .cfgDense(cfgDense), .cfgStableSel(cfgStableSel),
    .ctrl(ctrl), .dvfsLevel(dvfsLevel), .divLevel(divLevel),
    .dvfsChange(dvfsChange), .divChange(divChange)
  );
endmodule

// File: rtl/dvfs_freq_governor_chk.sv
`timescale 1ns/1ps
module dvfs_freq_governor_chk #(
  parameter int SAMP_W       = 16,
  parameter int HOLDOFF_TIME = 100000
) (
  input logic              clk,
  input logic              rstN,
  input logic              sampleValid,
  input logic [SAMP_W-1:0] sampleLen,
  input logic [2:0]        dvfsLevel,
  input logic [2:0]        divLevel,
  input logic              dvfsChange,
  input logic              divChange
);
  localparam int GAP_CAP = HOLDOFF_TIME + 1;
  localparam int GAP_W   = $clog2(GAP_CAP + 2**SAMP_W + 1);

  logic [GAP_W-1:0] gapAcc, gapSum;
  logic             seenChg;

  assign gapSum = gapAcc + GAP_W'(sampleLen);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapAcc  <= '0;
      seenChg <= 1'b0;
    end else if (dvfsChange) begin
      gapAcc  <= sampleValid ? GAP_W'(sampleLen) : '0;
      seenChg <= 1'b1;
    end else if (sampleValid) begin
      gapAcc <= (gapSum > GAP_W'(GAP_CAP)) ? GAP_W'(GAP_CAP) : gapSum;
    end
  end

  // R4
  holdoff_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    dvfsChange |-> (!seenChg || gapAcc > GAP_W'(HOLDOFF_TIME)));

  // R6
  div_reset_on_dvfs_chk: assert property (@(posedge clk) disable iff (!rstN)
    dvfsChange |-> (divLevel == 3'd7));

  // R6
  dvfs_strobe_moves_chk: assert property (@(posedge clk) disable iff (!rstN)
    dvfsChange |-> (dvfsLevel != $past(dvfsLevel)));

  // R6
  dvfs_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dvfsChange |-> $stable(dvfsLevel));

  // R7
  div_strobe_moves_chk: assert property (@(posedge clk) disable iff (!rstN)
    divChange |-> (divLevel != $past(divLevel)));

  // R7
  div_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !divChange |-> $stable(divLevel));
endmodule

bind dvfs_freq_governor dvfs_freq_governor_chk #(
  .SAMP_W(SAMP_W), .HOLDOFF_TIME(HOLDOFF_TIME)
) chkInst (
  .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleLen(sampleLen),
  .dvfsLevel(dvfsLevel), .divLevel(divLevel),
  .dvfsChange(dvfsChange), .divChange(divChange)
);

// File: tb/dvfs_freq_governor_test.sv
`timescale 1ns/1ps
module dvfs_freq_governor_test;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         sampleValid = 1'b0;
  logic [15:0]  sampleMem = '0;
  logic [15:0]  sampleLen = '0;
  logic         cfgDense = 1'b0;
  logic [2:0]   cfgStableSel = '0;
  logic [511:0] cfgThr;
  logic [2:0]   dvfsLevel, divLevel;
  logic         dvfsChange, divChange;

  int checks = 0;
  int errors = 0;
  int dvfsPulses = 0;
  int divPulses = 0;

  always #2.5 clk = ~clk;

  dvfs_freq_governor uut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .sampleMem(sampleMem), .sampleLen(sampleLen),
    .cfgDense(cfgDense), .cfgStableSel(cfgStableSel), .cfgThr(cfgThr),
    .dvfsLevel(dvfsLevel), .divLevel(divLevel),
    .dvfsChange(dvfsChange), .divChange(divChange)
  );

  // down: 128+16*(c-t); up: 64-4*(t-c); diagonal unused
  function automatic logic [511:0] mkTable();
    logic [511:0] tbl = '0;
    for (int c = 0; c < 8; c++) begin
      for (int t = 0; t < 8; t++) begin
        int v;
        if (t < c) v = 128 + 16 * (c - t);
        else if (t > c) v = 64 - 4 * (t - c);
        else v = 0;
        tbl[8*(8*c+t) +: 8] = 8'(v);
      end
    end
    return tbl;
  endfunction

  always @(negedge clk) begin
    if (rstN) begin
      if (dvfsChange) dvfsPulses++;
      if (divChange) divPulses++;
    end
  end

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic doReset(input logic dense, input logic [2:0] sel);
    @(negedge clk);
    rstN = 1'b0;
    sampleValid = 1'b0;
    cfgDense = dense;
    cfgStableSel = sel;
    cfgThr = mkTable();
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    dvfsPulses = 0;
    divPulses = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic sendSample(input int mem, input int len, input int gap = 40);
    @(negedge clk);
    sampleValid = 1'b1;
    sampleMem = 16'(mem);
    sampleLen = 16'(len);
    @(negedge clk);
    sampleValid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic testReset();
    doReset(1'b0, 3'd0);
    repeat (10) @(negedge clk);
    checkEq("R1", "dvfsLevel after reset", int'(dvfsLevel), 7);
    checkEq("R1", "divLevel after reset", int'(divLevel), 7);
    checkEq("R1", "strobes after reset", dvfsPulses + divPulses, 0);
  endtask

  task automatic testDivider();
    doReset(1'b0, 3'd4);
    sendSample(700, 1000);
    checkEq("R7", "div for 179/256", int'(divLevel), 4);
    sendSample(100, 1000);
    checkEq("R7", "div back to none", int'(divLevel), 7);
    sendSample(1000, 1000);
    checkEq("R11", "div for full memory time", int'(divLevel), 0);
    sendSample(9, 16);
    checkEq("R9", "div at exact threshold", int'(divLevel), 7);
    sendSample(10, 16);
    checkEq("R9", "div just above one-step threshold", int'(divLevel), 6);
    checkEq("R7", "divider pulses", divPulses, 5);
    checkEq("R5", "dvfs held by steadiness", int'(dvfsLevel), 7);
  endtask

  task automatic testStability();
    doReset(1'b0, 3'd1);
    sendSample(700, 1000);
    checkEq("R5", "dvfs after first sample", int'(dvfsLevel), 7);
    checkEq("R7", "div after first sample", int'(divLevel), 4);
    sendSample(700, 1000);
    checkEq("R5", "dvfs below limit", int'(dvfsLevel), 7);
    sendSample(700, 1000);
    checkEq("R5", "dvfs once steady", int'(dvfsLevel), 4);
    checkEq("R6", "div reset on dvfs change", int'(divLevel), 7);
    checkEq("R6", "dvfs pulses", dvfsPulses, 1);
    checkEq("R6", "div pulses", divPulses, 2);
  endtask

  task automatic testHoldoff();
    doReset(1'b0, 3'd1);
    for (int i = 0; i < 3; i++) sendSample(700, 1000);
    checkEq("R4", "first change", int'(dvfsLevel), 4);
    for (int i = 0; i < 100; i++) sendSample(1000, 1000);
    checkEq("R4", "held at exactly the spacing", int'(dvfsLevel), 4);
    checkEq("R7", "div follows sample in hold-off", int'(divLevel), 0);
    sendSample(1000, 1000);
    checkEq("R4", "change past spacing", int'(dvfsLevel), 0);
    checkEq("R6", "div reset beats sample", int'(divLevel), 7);
    checkEq("R4", "dvfs pulses", dvfsPulses, 2);
  endtask

  task automatic testWindow();
    doReset(1'b0, 3'd0);
    for (int i = 0; i < 12; i++) sendSample(0, 2000);
    checkEq("R2", "idle window", int'(dvfsLevel), 7);
    for (int i = 0; i < 7; i++) sendSample(2000, 2000);
    checkEq("R2", "7 of 13 busy", int'(dvfsLevel), 7);
    sendSample(2000, 2000);
    checkEq("R2", "8 of 13 busy", int'(dvfsLevel), 6);
  endtask

  task automatic testAbsTime();
    doReset(1'b0, 3'd6);
    for (int i = 0; i < 6; i++) sendSample(0, 5000, (i % 2 == 0) ? 40 : 200);
    sendSample(5000, 5000, 150);
    sendSample(5000, 5000, 30);
    checkEq("R3", "2 of 5 busy", int'(dvfsLevel), 7);
    sendSample(5000, 5000, 90);
    checkEq("R3", "3 of 5 busy", int'(dvfsLevel), 6);
  endtask

  task automatic testFull();
    doReset(1'b0, 3'd0);
    for (int i = 0; i < 16; i++) sendSample(0, 1000);
    for (int i = 0; i < 9; i++) sendSample(1000, 1000);
    checkEq("R12", "9 of 16 busy at threshold", int'(dvfsLevel), 7);
    sendSample(1000, 1000);
    checkEq("R12", "10 of 16 busy", int'(dvfsLevel), 6);
  endtask

  task automatic testDense();
    doReset(1'b1, 3'd4);
    sendSample(700, 1000);
    checkEq("R8", "dense ignores steadiness", int'(dvfsLevel), 4);
    checkEq("R8", "div stays none", int'(divLevel), 7);
    for (int i = 0; i < 100; i++) sendSample(225, 1000);
    checkEq("R8", "dense held by spacing", int'(dvfsLevel), 4);
    sendSample(225, 1000);
    checkEq("R10", "largest upward level", int'(dvfsLevel), 5);
    checkEq("R6", "no div pulse when already none", divPulses, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cfgThr = mkTable();
    testReset();
    testDivider();
    testStability();
    testHoldoff();
    testWindow();
    testAbsTime();
    testFull();
    testDense();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule